// File: doc/BRIEF.md
# Integer ALU with Carry, Overflow and Condition Flags

This block is the integer execution stage of a 32-bit core. Each valid operation takes two operands and an operation code, and computes one of add, add with carry-in, AND, OR, XOR or NOT. The result is registered onto a destination write port. Three control bits come with each operation and choose its side effects. The first loads the stored carry flag. The second rewrites the overflow flag and can raise the sticky summary-overflow flag. The third writes a 4-bit condition field that describes the result.

The flag register holds three bits: carry (CA), overflow (OV) and summary overflow (SO). Add-with-carry takes its carry-in from the stored CA bit. SO works as an accumulator. Any operation with its overflow control set that overflows raises SO, and only reset clears it. An enabled operation that does not overflow clears OV and leaves SO as it is. All state changes on the rising clock edge, and only when the valid strobe is high.

Top module: `int_alu_flags`

## Requirements
- R1: A synchronous reset clears CA, OV and SO, and also clears `destWe`, `crWe`, `destData` and `crField`.
- R2: Operation code 0 is add. On the edge after an operation with `opValid` high, `destData` holds `opA + opB` modulo 2^32 and `destWe` is 1 for that cycle.
- R3: Operation code 1 is add with carry-in. The result is `opA + opB + CA`, using the CA value stored before the operation.
- R4: With `carryEn` set, CA is loaded with bit 32 of the zero-extended 33-bit sum. Logical operations load CA with 0.
- R5: With `ovEn` set and signed overflow present, OV and SO both become 1. Signed overflow means that bits 32 and 31 of the sign-extended 33-bit sum differ. OV = 1 always implies SO = 1.
- R6: With `ovEn` set and no signed overflow, OV becomes 0 and SO keeps its value. SO never falls except on reset.
- R7: Operation codes 2, 3, 4 and 5 are AND, OR, XOR and NOT of `opA`. None of them produces a carry or an overflow.
- R8: With `recEn` set, `crWe` pulses and `crField` is {negative, positive, zero, SO}, from bit 3 down to bit 0. The flags compare the signed result with zero, and the SO bit is the value after this operation's own update.
- R9: A cleared enable leaves its flag unchanged. A cycle with `opValid` low changes no flag and raises neither `destWe` nor `crWe`.
- R10: Operation codes 6 and 7 give a zero result with no carry and no overflow.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| opValid | input | 1 | Operation strobe |
| opCode | input | 3 | Operation select |
| opA | input | 32 | First operand |
| opB | input | 32 | Second operand |
| carryEn | input | 1 | Update CA |
| ovEn | input | 1 | Update OV and SO |
| recEn | input | 1 | Write the condition field |
| destData | output | 32 | Registered result |
| destWe | output | 1 | Destination write strobe |
| crWe | output | 1 | Condition-field write strobe |
| crField | output | 4 | Condition field {neg, pos, zero, SO} |
| flagCa | output | 1 | Carry flag |
| flagOv | output | 1 | Overflow flag |
| flagSo | output | 1 | Summary overflow flag |

## Verification
The flag bits appear directly on the ports. A wrong CA, OV or SO value is therefore visible one edge after the operation that wrote it. A wrong CA also shows up indirectly in the next add-with-carry result. A wrong SO shows up in bit 0 of every later recorded condition field. The bench runs operations in sequence, so a stale or wrongly sticky flag is caught on the very next operation that depends on it.

// File: rtl/int_alu_pkg.sv
package int_alu_pkg;

  typedef enum logic [2:0] {
    OP_ADD  = 3'd0,
    OP_ADDC = 3'd1,
    OP_AND  = 3'd2,
    OP_OR   = 3'd3,
    OP_XOR  = 3'd4,
    OP_NOT  = 3'd5
  } aluOp_e;

  // strobes from the control to the datapath
  typedef struct packed {
    logic fire;     // operation accepted this edge
    logic wrCa;     // load carry flag
    logic wrOv;     // load overflow / raise summary overflow
    logic wrCr;     // write condition field
    logic useCin;   // feed stored carry into the adder
  } ctrlStrobe_t;

endpackage

// File: rtl/alu_ctrl.sv
module alu_ctrl
  import int_alu_pkg::*;
(
  input  logic        opValid,
  input  logic [2:0]  opCode,
  input  logic        carryEn,
  input  logic        ovEn,
  input  logic        recEn,
  output ctrlStrobe_t strobe
);

  always_comb begin
    strobe.fire   = opValid;
    strobe.wrCa   = opValid & carryEn;
    strobe.wrOv   = opValid & ovEn;
    strobe.wrCr   = opValid & recEn;
    strobe.useCin = (aluOp_e'(opCode) == OP_ADDC);
  end

endmodule

// File: rtl/alu_datapath.sv
module alu_datapath
  import int_alu_pkg::*;
#(
  parameter int DATA_W = 32
) (
  input  logic              clk,
  input  logic              rst,
  input  ctrlStrobe_t       strobe,
  input  logic [2:0]        opCode,
  input  logic [DATA_W-1:0] opA,
  input  logic [DATA_W-1:0] opB,
  output logic [DATA_W-1:0] destData,
  output logic              destWe,
  output logic              crWe,
  output logic [3:0]        crField,
  output logic              flagCa,
  output logic              flagOv,
  output logic              flagSo
);

  localparam int EXT_W = DATA_W + 1;
  localparam int MSB   = DATA_W - 1;

  logic              caQ, ovQ, soQ;
  logic              carryIn;
  logic [EXT_W-1:0]  uSum;
  logic [DATA_W-1:0] res;
  logic              carryOut, ovOut, soNext;
  logic              resNeg, resZero, resPos;

  always_comb begin
    carryIn = strobe.useCin & caQ;
    uSum    = {1'b0, opA} + {1'b0, opB} + EXT_W'(carryIn);
    res      = '0;
    carryOut = 1'b0;
    ovOut    = 1'b0;
    unique case (opCode)
      3'd0, 3'd1: begin
        res      = uSum[MSB:0];
        carryOut = uSum[DATA_W];
        // top bit of the sign-extended sum is a^b^carry-out; compare with msb
        ovOut    = opA[MSB] ^ opB[MSB] ^ uSum[DATA_W] ^ uSum[MSB];
      end
      3'd2: res = opA & opB;
      3'd3: res = opA | opB;
      3'd4: res = opA ^ opB;
      3'd5: res = ~opA;
      default: res = '0;
    endcase
    soNext  = soQ | (strobe.wrOv & ovOut);
    resNeg  = res[MSB];
    resZero = (res == '0);
    resPos  = ~resNeg & ~resZero;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      caQ      <= 1'b0;
      ovQ      <= 1'b0;
      soQ      <= 1'b0;
      destData <= '0;
      destWe   <= 1'b0;
      crWe     <= 1'b0;
      crField  <= '0;
    end else begin
      destWe <= strobe.fire;
      crWe   <= strobe.wrCr;
      if (strobe.fire) destData <= res;
      if (strobe.wrCa) caQ <= carryOut;
      if (strobe.wrOv) begin
        ovQ <= ovOut;
        soQ <= soNext;
      end
      if (strobe.wrCr) crField <= {resNeg, resPos, resZero, soNext};
    end
  end

  assign flagCa = caQ;
  assign flagOv = ovQ;
  assign flagSo = soQ;

  // summary overflow only falls on reset
  assert_so_sticky_R6: assert property (@(posedge clk) disable iff (rst)
    soQ |=> soQ);

  // a set overflow flag always comes with a set summary flag
  assert_ov_implies_so_R5: assert property (@(posedge clk) disable iff (rst)
    ovQ |-> soQ);

  // carry holds when its write strobe is low
  assert_ca_hold_R9: assert property (@(posedge clk) disable iff (rst)
    !strobe.wrCa |=> $stable(caQ));

  // recorded field carries exactly one of neg/pos/zero
  assert_cr_onehot_R8: assert property (@(posedge clk) disable iff (rst)
    crWe |-> ($countones(crField[3:1]) == 1));

  // destination strobe only follows an accepted operation
  assert_dest_follows_valid_R9: assert property (@(posedge clk) disable iff (rst)
    !strobe.fire |=> !destWe);

endmodule

// File: rtl/int_alu_flags.sv
module int_alu_flags
  import int_alu_pkg::*;
#(
  parameter int DATA_W = 32
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              opValid,
  input  logic [2:0]        opCode,
  input  logic [DATA_W-1:0] opA,
  input  logic [DATA_W-1:0] opB,
  input  logic              carryEn,
  input  logic              ovEn,
  input  logic              recEn,
  output logic [DATA_W-1:0] destData,
  output logic              destWe,
  output logic              crWe,
  output logic [3:0]        crField,
  output logic              flagCa,
  output logic              flagOv,
  output logic              flagSo
);

  ctrlStrobe_t strobe;

  alu_ctrl u_ctrl (
    .opValid (opValid),
    .opCode  (opCode),
    .carryEn (carryEn),
    .ovEn    (ovEn),
    .recEn   (recEn),
    .strobe  (strobe)
  );

  alu_datapath #(.DATA_W(DATA_W)) u_dp (
    .clk      (clk),
    .rst      (rst),
    .strobe   (strobe),
    .opCode   (opCode),
    .opA      (opA),
    .opB      (opB),
    .destData (destData),
    .destWe   (destWe),
    .crWe     (crWe),
    .crField  (crField),
    .flagCa   (flagCa),
    .flagOv   (flagOv),
    .flagSo   (flagSo)
  );

endmodule

// File: tb/sim_int_alu_flags.sv
`timescale 1ns/1ps
module sim_int_alu_flags;

  logic        clk = 1'b0;
  logic        rst;
  logic        opValid;
  logic [2:0]  opCode;
  logic [31:0] opA, opB;
  logic        carryEn, ovEn, recEn;
  logic [31:0] destData;
  logic        destWe, crWe;
  logic [3:0]  crField;
  logic        flagCa, flagOv, flagSo;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  // bench model of the flags
  logic mCa, mOv, mSo;

  always #4 clk = ~clk;

  int_alu_flags u0 (
    .clk(clk), .rst(rst), .opValid(opValid), .opCode(opCode),
    .opA(opA), .opB(opB), .carryEn(carryEn), .ovEn(ovEn), .recEn(recEn),
    .destData(destData), .destWe(destWe), .crWe(crWe), .crField(crField),
    .flagCa(flagCa), .flagOv(flagOv), .flagSo(flagSo)
  );

  // {op[3], a[32], b[32], {carryEn,ovEn,recEn}, expected result[32]}
  localparam int NVEC = 12;
  localparam logic [101:0] vecTab [NVEC] = '{
    {3'd0, 32'd5,         32'd7,         3'b111, 32'd12},
    {3'd0, 32'hFFFFFFFF,  32'd1,         3'b101, 32'd0},
    {3'd1, 32'd10,        32'd20,        3'b100, 32'd31},
    {3'd0, 32'h7FFFFFFF,  32'd1,         3'b011, 32'h80000000},
    {3'd0, 32'd1,         32'd1,         3'b010, 32'd2},
    {3'd2, 32'hF0F0F0F0,  32'h0FF00FF0,  3'b001, 32'h00F000F0},
    {3'd3, 32'h12340000,  32'h00005678,  3'b000, 32'h12345678},
    {3'd4, 32'hFFFF0000,  32'hFF00FF00,  3'b001, 32'h00FFFF00},
    {3'd5, 32'h00000000,  32'h0,         3'b111, 32'hFFFFFFFF},
    {3'd0, 32'h80000000,  32'h80000000,  3'b111, 32'd0},
    {3'd1, 32'd0,         32'd0,         3'b001, 32'd1},
    {3'd7, 32'h00001234,  32'h00005678,  3'b001, 32'd0}
  };

  task automatic check(input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  task automatic checkFlags(input string req);
    check(req, "CA", 32'(flagCa), 32'(mCa));
    check(req, "OV", 32'(flagOv), 32'(mOv));
    check(req, "SO", 32'(flagSo), 32'(mSo));
  endtask

  // called at a falling edge; returns at the next falling edge
  task automatic runOp(input logic [2:0] op, input logic [31:0] a,
                       input logic [31:0] b, input logic [2:0] en,
                       input logic [31:0] expRes);
    logic [32:0] s33;
    logic cin, isAdd, cOut, ov;
    logic [3:0] expCr;
    string rq;
    opCode = op; opA = a; opB = b;
    {carryEn, ovEn, recEn} = en;
    opValid = 1'b1;
    cin   = (op == 3'd1) ? mCa : 1'b0;
    isAdd = (op <= 3'd1);
    s33   = {1'b0, a} + {1'b0, b} + 33'(cin);
    cOut  = isAdd ? s33[32] : 1'b0;
    ov    = isAdd ? ((a[31] == b[31]) && (s33[31] != a[31])) : 1'b0;
    if (en[2]) mCa = cOut;
    if (en[1]) begin
      mOv = ov;
      if (ov) mSo = 1'b1;
    end
    expCr = {expRes[31], !expRes[31] && (expRes != 0), expRes == 0, mSo};
    @(negedge clk);
    opValid = 1'b0;
    case (op)
      3'd0: rq = "R2";
      3'd1: rq = "R3";
      3'd2, 3'd3, 3'd4, 3'd5: rq = "R7";
      default: rq = "R10";
    endcase
    check(rq, "result", destData, expRes);
    check(rq, "destWe", 32'(destWe), 32'd1);
    check("R4", "CA", 32'(flagCa), 32'(mCa));
    check(ov ? "R5" : "R6", "OV", 32'(flagOv), 32'(mOv));
    check(ov ? "R5" : "R6", "SO", 32'(flagSo), 32'(mSo));
    check("R8", "crWe", 32'(crWe), 32'(en[0]));
    if (en[0]) check("R8", "crField", 32'(crField), 32'(expCr));
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog expired actual=running expected=done");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    rst = 1'b1; opValid = 1'b0; opCode = '0; opA = '0; opB = '0;
    carryEn = 1'b0; ovEn = 1'b0; recEn = 1'b0;
    mCa = 1'b0; mOv = 1'b0; mSo = 1'b0;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    // R1 reset state
    check("R1", "destWe", 32'(destWe), 32'd0);
    check("R1", "crWe", 32'(crWe), 32'd0);
    check("R1", "destData", destData, 32'd0);
    check("R1", "crField", 32'(crField), 32'd0);
    checkFlags("R1");

    for (int i = 0; i < NVEC; i++)
      runOp(vecTab[i][101:99], vecTab[i][98:67], vecTab[i][66:35],
            vecTab[i][34:32], vecTab[i][31:0]);

    // R9 idle cycle with busy inputs: nothing changes
    opCode = 3'd0; opA = 32'h7FFFFFFF; opB = 32'h7FFFFFFF;
    carryEn = 1'b1; ovEn = 1'b1; recEn = 1'b1; opValid = 1'b0;
    @(negedge clk);
    check("R9", "destWe idle", 32'(destWe), 32'd0);
    check("R9", "crWe idle", 32'(crWe), 32'd0);
    checkFlags("R9");

    // R9 enables cleared on an overflowing, carrying add: flags held
    runOp(3'd0, 32'hFFFFFFFF, 32'h80000000, 3'b000, 32'h7FFFFFFF);
    checkFlags("R9");

    // R1 reset mid-run clears sticky state
    rst = 1'b1;
    @(negedge clk);
    rst = 1'b0;
    mCa = 1'b0; mOv = 1'b0; mSo = 1'b0;
    checkFlags("R1");
    check("R1", "destWe", 32'(destWe), 32'd0);

    // R3 carry-in after reset is zero
    runOp(3'd1, 32'd5, 32'd5, 3'b000, 32'd10);
    // R5 overflow raises SO from clear
    runOp(3'd0, 32'h7FFFFFFF, 32'd1, 3'b011, 32'h80000000);
    // R6 no overflow clears OV, SO stays
    runOp(3'd2, 32'hFFFFFFFF, 32'h00000000, 3'b011, 32'd0);

    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule